// File: doc/BRIEF.md
# Power-Management Clock Divider with Automatic Return to Full Speed

This block derives the machine-cycle clock enable of a small processor core from the raw oscillator clock. It supports three divide ratios. Full speed gives one enable pulse every 4 oscillator cycles. A low-power ratio gives one every 64 cycles, and a deep low-power ratio gives one every 1024 cycles. Software picks the ratio by writing two request bits. The active ratio is taken up only when the current divided period ends, so no machine cycle is ever cut short.

The block can also return to full speed without any software action. When this option is enabled, either of two events clears the request bits: an interrupt acknowledge from the core, or a falling edge (a start bit) on the serial receive pin. The divider then runs at full speed from the next period boundary. This means a serial frame, or an interrupt handler, starts at full speed. The receive pin is asynchronous and passes through a two-flop synchronizer before edge detection.

Top module: `pm_clkdiv`

## Requirements
- R1: After reset the request bits read 0, the active speed reads 0 (full speed), and the first `cycle_en` pulse appears in the 4th oscillator cycle after reset is released.
- R2: At full speed (active speed code 0), `cycle_en` is a single-cycle pulse repeating every 4 oscillator cycles.
- R3: Request bits 01 (bit 0 set, bit 1 clear) select the low-power ratio, code 1, with one pulse every 64 cycles.
- R4: Request bit 1 set selects the deep ratio, code 2, with one pulse every 1024 cycles. Bit 1 wins when both bits are written as 11.
- R5: A change of the request bits does not alter the period in progress. The new ratio applies from the cycle after the next `cycle_en` pulse, and `speed_now` changes only in the cycle right after a pulse.
- R6: With `sb_enable` high and nonzero request bits, an `irq_ack` sampled at a clock edge clears the request bits at that edge. Full speed follows from the next period boundary.
- R7: With `sb_enable` high and nonzero request bits, a high-to-low change on `rx_pin` clears the request bits at the third rising edge that samples `rx_pin` low, and not earlier.
- R8: With `sb_enable` low, `irq_ack` and `rx_pin` edges leave the request bits unchanged.
- R9: A `cfg_wr` in the same cycle as a switchback event wins: the written value is stored.
- R10: `speed_now` only ever takes the codes 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_osc_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk_osc |
| cfg_wr | input | 1 | Write strobe for the request bits |
| cfg_wdata | input | 2 | Request bits to write: bit 0 low-power, bit 1 deep low-power |
| irq_ack | input | 1 | Interrupt acknowledge strobe from the core |
| rx_pin | input | 1 | Asynchronous serial receive pin, idle high |
| sb_enable | input | 1 | Enables automatic return to full speed |
| cycle_en | output | 1 | One-cycle machine-cycle clock enable |
| speed_bits | output | 2 | Current request bits as software reads them |
| speed_now | output | 2 | Ratio in effect: 0 full, 1 low-power, 2 deep |

## Verification
The checks assume that `rst_osc_n` is released in step with `clk_osc`, and that `cfg_wr`, `irq_ack` and `sb_enable` are synchronous to `clk_osc`. Only `rx_pin` is allowed to change freely. The bench drives every input half a cycle away from the active edge, so this assumption holds. Random stimulus keeps writes and acknowledges rare, so that whole 64- and 1024-cycle periods do complete between events. The receive pin is toggled at random, both while a reduced ratio is requested and while the switchback option is off.

// File: rtl/pm_clkdiv_pkg.sv
package pm_clkdiv_pkg;

  typedef enum logic [1:0] {
    SPD_FULL = 2'd0,
    SPD_LOW  = 2'd1,
    SPD_DEEP = 2'd2
  } speed_t;

  // Bit 1 has priority over bit 0; all-zero means full speed.
  function automatic speed_t decode_req(input logic [1:0] req);
    if (req[1])      return SPD_DEEP;
    else if (req[0]) return SPD_LOW;
    else             return SPD_FULL;
  endfunction

endpackage

// File: rtl/pm_clkdiv_rx_edge.sv
module pm_clkdiv_rx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async,
  output logic rx_fall
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], rx_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  // Last synchronized stage low while the history stage was high.
  assign rx_fall = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

endmodule

// File: rtl/pm_clkdiv_modereg.sv
module pm_clkdiv_modereg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_bits,
  input  logic       sb_enable,
  input  logic       irq_ack,
  input  logic       rx_fall,
  output logic [1:0] req_bits
);
  logic [1:0] req_q;
  logic [1:0] req_d;
  logic       sb_event;

  always_comb begin
    sb_event = sb_enable & (irq_ack | rx_fall) & (req_q != 2'b00);
    req_d    = req_q;
    if (wr_en)         req_d = wr_bits;
    else if (sb_event) req_d = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 2'b00;
    else        req_q <= req_d;
  end

  assign req_bits = req_q;

endmodule

// File: rtl/pm_clkdiv_counter.sv
module pm_clkdiv_counter
  import pm_clkdiv_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int FULL_DIV = 4,
  parameter int LOW_DIV  = 64,
  parameter int DEEP_DIV = 1024
) (
  input  logic   clk,
  input  logic   rst_n,
  input  speed_t req_speed,
  output logic   cycle_en,
  output speed_t act_speed
);
  localparam logic [CNT_W-1:0] TC_FULL = CNT_W'(FULL_DIV - 1);
  localparam logic [CNT_W-1:0] TC_LOW  = CNT_W'(LOW_DIV - 1);
  localparam logic [CNT_W-1:0] TC_DEEP = CNT_W'(DEEP_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] tc_sel;
  speed_t           act_q, act_d;
  logic             at_tc;

  always_comb begin
    unique case (act_q)
      SPD_LOW:  tc_sel = TC_LOW;
      SPD_DEEP: tc_sel = TC_DEEP;
      default:  tc_sel = TC_FULL;
    endcase
    at_tc = (cnt_q == tc_sel);
    cnt_d = at_tc ? '0 : cnt_q + 1'b1;
    act_d = at_tc ? req_speed : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= SPD_FULL;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign cycle_en  = at_tc;
  assign act_speed = act_q;

endmodule

// File: rtl/pm_clkdiv.sv
module pm_clkdiv
  import pm_clkdiv_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int FULL_DIV    = 4,
  parameter int LOW_DIV     = 64,
  parameter int DEEP_DIV    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_osc,
  input  logic       rst_osc_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_wdata,
  input  logic       irq_ack,
  input  logic       rx_pin,
  input  logic       sb_enable,
  output logic       cycle_en,
  output logic [1:0] speed_bits,
  output logic [1:0] speed_now
);
  logic   rx_fall;
  logic [1:0] req_bits;
  speed_t req_speed;
  speed_t act_speed;

  pm_clkdiv_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_rx_edge (
    .clk      (clk_osc),
    .rst_n    (rst_osc_n),
    .rx_async (rx_pin),
    .rx_fall  (rx_fall)
  );

  pm_clkdiv_modereg u_modereg (
    .clk       (clk_osc),
    .rst_n     (rst_osc_n),
    .wr_en     (cfg_wr),
    .wr_bits   (cfg_wdata),
    .sb_enable (sb_enable),
    .irq_ack   (irq_ack),
    .rx_fall   (rx_fall),
    .req_bits  (req_bits)
  );

  assign req_speed = decode_req(req_bits);

  pm_clkdiv_counter #(
    .CNT_W    (CNT_W),
    .FULL_DIV (FULL_DIV),
    .LOW_DIV  (LOW_DIV),
    .DEEP_DIV (DEEP_DIV)
  ) u_counter (
    .clk       (clk_osc),
    .rst_n     (rst_osc_n),
    .req_speed (req_speed),
    .cycle_en  (cycle_en),
    .act_speed (act_speed)
  );

  assign speed_bits = req_bits;
  assign speed_now  = act_speed;

endmodule

// File: rtl/pm_clkdiv_chk.sv
module pm_clkdiv_chk #(
  parameter int FULL_DIV = 4,
  parameter int LOW_DIV  = 64,
  parameter int DEEP_DIV = 1024
) (
  input logic       clk_osc,
  input logic       rst_osc_n,
  input logic       cfg_wr,
  input logic [1:0] cfg_wdata,
  input logic       irq_ack,
  input logic       sb_enable,
  input logic       rx_fall,
  input logic       cycle_en,
  input logic [1:0] speed_bits,
  input logic [1:0] speed_now
);
  localparam int GAP_W = $clog2(DEEP_DIV + 1) + 1;

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_osc or negedge rst_osc_n) begin
    if (!rst_osc_n)    gap_q <= GAP_W'(1);
    else if (cycle_en) gap_q <= GAP_W'(1);
    else               gap_q <= gap_q + 1'b1;
  end

  function automatic logic [GAP_W-1:0] span_of(input logic [1:0] code);
    case (code)
      2'd1:    return GAP_W'(LOW_DIV);
      2'd2:    return GAP_W'(DEEP_DIV);
      default: return GAP_W'(FULL_DIV);
    endcase
  endfunction

  // Covers R2, R3 and R4: pulse spacing follows the active ratio.
  assert_pulse_spacing_R2: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
    cycle_en |-> (gap_q == span_of(speed_now)));

  assert_boundary_only_R5: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
    !$past(cycle_en) |-> $stable(speed_now));

  assert_irq_return_R6: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
    (sb_enable && irq_ack && speed_bits != 2'b00 && !cfg_wr) |=> (speed_bits == 2'b00));

  assert_rx_return_R7: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
    (sb_enable && rx_fall && speed_bits != 2'b00 && !cfg_wr) |=> (speed_bits == 2'b00));

  assert_return_off_R8: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
    (!sb_enable && !cfg_wr) |=> $stable(speed_bits));

  assert_write_wins_R9: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
    cfg_wr |=> (speed_bits == $past(cfg_wdata)));

  assert_legal_speed_R10: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
    speed_now != 2'd3);

endmodule

bind pm_clkdiv pm_clkdiv_chk #(
  .FULL_DIV (FULL_DIV),
  .LOW_DIV  (LOW_DIV),
  .DEEP_DIV (DEEP_DIV)
) u_chk (
  .clk_osc    (clk_osc),
  .rst_osc_n  (rst_osc_n),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .irq_ack    (irq_ack),
  .sb_enable  (sb_enable),
  .rx_fall    (rx_fall),
  .cycle_en   (cycle_en),
  .speed_bits (speed_bits),
  .speed_now  (speed_now)
);

// File: tb/pm_clkdiv_test.sv
module pm_clkdiv_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk_osc = 1'b0;
  logic       rst_osc_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic       irq_ack = 1'b0;
  logic       rx_pin = 1'b1;
  logic       sb_enable = 1'b0;
  logic       cycle_en;
  logic [1:0] speed_bits;
  logic [1:0] speed_now;

  int n_vec = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference state built from the requirements.
  logic [1:0] m_bits;
  int         m_act;
  int         m_pos;
  logic [2:0] m_sync;
  logic       rx_lvl = 1'b1;
  logic       sb_lvl = 1'b0;

  pm_clkdiv uut (
    .clk_osc    (clk_osc),
    .rst_osc_n  (rst_osc_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .irq_ack    (irq_ack),
    .rx_pin     (rx_pin),
    .sb_enable  (sb_enable),
    .cycle_en   (cycle_en),
    .speed_bits (speed_bits),
    .speed_now  (speed_now)
  );

  always #(CLK_PERIOD/2) clk_osc = ~clk_osc;

  function automatic int span(input int code);
    if (code == 2) return 1024;
    if (code == 1) return 64;
    return 4;
  endfunction

  function automatic int req_code(input logic [1:0] b);
    if (b[1]) return 2;
    if (b[0]) return 1;
    return 0;
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_bits = 2'b00; m_act = 0; m_pos = 0; m_sync = 3'b111;
  endtask

  task automatic step(input logic wr, input logic [1:0] wd, input logic ack);
    logic fall;
    logic term;
    check("R2 R3 R4 cycle_en", {11'd0, cycle_en}, {11'd0, (m_pos == span(m_act) - 1)});
    check("R10 speed_now", {10'd0, speed_now}, 12'(m_act));
    check("R6 R7 R9 speed_bits", {10'd0, speed_bits}, {10'd0, m_bits});
    cfg_wr = wr; cfg_wdata = wd; irq_ack = ack; rx_pin = rx_lvl; sb_enable = sb_lvl;
    fall = m_sync[2] & ~m_sync[1];
    term = (m_pos == span(m_act) - 1);
    if (term) begin m_pos = 0; m_act = req_code(m_bits); end
    else m_pos++;
    if (wr) m_bits = wd;
    else if (sb_lvl && m_bits != 2'b00 && (ack || fall)) m_bits = 2'b00;
    m_sync = {m_sync[1:0], rx_lvl};
    @(posedge clk_osc);
    @(negedge clk_osc);
    cfg_wr = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 2'b00, 1'b0);
  endtask

  task automatic wait_pulse();
    while (cycle_en !== 1'b1) idle();
  endtask

  task automatic measure(output int n);
    wait_pulse();
    idle();
    n = 1;
    while (cycle_en !== 1'b1) begin idle(); n++; end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_osc);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk_osc);
    rst_osc_n = 1'b1;
    // R1: state right after reset
    check("R1 speed_bits", {10'd0, speed_bits}, 12'd0);
    check("R1 speed_now", {10'd0, speed_now}, 12'd0);
    check("R1 cycle_en idle", {11'd0, cycle_en}, 12'd0);
    idle(); idle(); idle();
    check("R1 first pulse", {11'd0, cycle_en}, 12'd1);
    measure(n);
    check("R2 full period", 12'(n), 12'd4);

    // R5: write mid-period, old period completes
    wait_pulse(); idle();
    step(1'b1, 2'b01, 1'b0);
    n = 0;
    while (cycle_en !== 1'b1) begin idle(); n++; end
    check("R5 remaining old period", 12'(n), 12'd2);
    measure(n);
    check("R3 low-power period", 12'(n), 12'd64);
    check("R3 speed_now", {10'd0, speed_now}, 12'd1);

    // R4: both bits set -> deep
    step(1'b1, 2'b11, 1'b0);
    wait_pulse(); idle();
    check("R4 speed_now", {10'd0, speed_now}, 12'd2);
    measure(n);
    check("R4 deep period", 12'(n), 12'd1024);

    // R6: interrupt acknowledge returns to full speed
    sb_lvl = 1'b1; idle();
    step(1'b0, 2'b00, 1'b1);
    check("R6 bits cleared", {10'd0, speed_bits}, 12'd0);
    wait_pulse(); idle();
    measure(n);
    check("R6 full period after return", 12'(n), 12'd4);

    // R7: start bit on rx
    step(1'b1, 2'b01, 1'b0);
    wait_pulse(); idle();
    rx_lvl = 1'b0;
    idle();
    check("R7 not after 1st low sample", {10'd0, speed_bits}, 12'd1);
    idle();
    check("R7 not after 2nd low sample", {10'd0, speed_bits}, 12'd1);
    idle();
    check("R7 cleared after 3rd low sample", {10'd0, speed_bits}, 12'd0);
    rx_lvl = 1'b1; idle(); idle();

    // R8: switchback disabled
    sb_lvl = 1'b0;
    step(1'b1, 2'b10, 1'b0);
    step(1'b0, 2'b00, 1'b1);
    check("R8 ack ignored", {10'd0, speed_bits}, 12'd2);
    rx_lvl = 1'b0;
    repeat (4) idle();
    check("R8 rx edge ignored", {10'd0, speed_bits}, 12'd2);
    rx_lvl = 1'b1; repeat (3) idle();

    // R9: write wins over simultaneous acknowledge
    sb_lvl = 1'b1; idle();
    step(1'b1, 2'b01, 1'b1);
    check("R9 write wins", {10'd0, speed_bits}, 12'd1);

    // Constrained random traffic
    for (int i = 0; i < 40000; i++) begin
      logic wr, ack;
      if (($urandom % 500) == 0) sb_lvl = ~sb_lvl;
      if (($urandom % 40) == 0)  rx_lvl = ~rx_lvl;
      wr  = (($urandom % 400) == 0);
      ack = (($urandom % 250) == 0);
      step(wr, 2'($urandom), ack);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule